// File: doc/BRIEF.md
# AES-GCM Stream Phase Sequencer

This block orders the work around an authenticated-encryption datapath that runs in Galois/counter mode. It does not contain the block cipher or the Galois-field multiplier. Those sit behind handshake ports. The sequencer reads a programmed associated-data byte count and a payload byte count, then steps through four phases. First it requests the precompute of the hash subkey and the encrypted first counter. Then it accepts the associated-data blocks, then the payload blocks, and finally it signals that the tag is ready.

Software or a DMA engine feeds 128-bit words when the input trigger is high and collects results when the output trigger is high. Each trigger has its own enable. Associated-data blocks go to the datapath and give no result. Payload results come back through a small result buffer. Up to two payload blocks may be accepted but not yet read, so results trail the inputs and the last reads drain the pipeline. In the final block of each phase, the bytes beyond the programmed length are forced to zero before the block reaches the datapath.

When key and control stay the same, a new stream only needs new lengths and a new start pulse.

Top module: `gcm_phase_seq`

## Requirements
- R1: After reset, all of `in_trig`, `out_trig`, `pc_go`, `tag_clr`, `done`, `tag_rdy` and `err` are low.
- R2: A `start` pulse taken while idle or in the tag phase, with at least one length non-zero, gives `pc_go` and `tag_clr` high for exactly the next cycle. No input is requested until `pc_done` has been seen.
- R3: A `start` with both lengths zero sets `err`. It raises no `pc_go`, no `tag_clr` and no trigger, and the block stays idle. The next legal start clears `err`.
- R4: Exactly ceil(aad_len/16) blocks go to the datapath with `core_aad`=1. All of them come before any payload block, and they produce no result and no output trigger.
- R5: The payload byte count is `{pay_len_hi, pay_len_lo}`, with the low part in the low bits. Exactly ceil(count/16) payload blocks are accepted. Each result appears on `out_data` in input order.
- R6: At most two payload blocks are accepted but not yet read. While two are outstanding, the input trigger stays low.
- R7: The last block of each phase carries `core_last`=1. In that block, every byte at index i >= (length mod 16), where byte i is bits [8i+7:8i], is zero. A length that is a multiple of 16 leaves the block whole.
- R8: `in_trig` is high only when `in_mask_en` is 1, and `out_trig` is high only when `out_mask_en` is 1. A disabled trigger loses no data.
- R9: After the last payload result is read, or after the last associated-data block is absorbed when there is no payload, `done` pulses for one cycle and `tag_rdy` stays high until the next start.
- R10: A `start` that arrives during the precompute, associated-data, payload or drain phase is ignored.
- R11: A start from the tag phase with new lengths runs a complete new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a stream with the present lengths |
| aad_len | input | 16 | Associated-data byte count |
| pay_len_lo | input | 32 | Payload byte count, low part |
| pay_len_hi | input | 4 | Payload byte count, high part |
| in_mask_en | input | 1 | Enable for the input trigger |
| out_mask_en | input | 1 | Enable for the output trigger |
| in_wr | input | 1 | Write strobe for an input word |
| in_data | input | 128 | Input word, byte 0 in bits 7:0 |
| in_trig | output | 1 | Input word requested |
| out_rd | input | 1 | Read strobe for a result |
| out_data | output | 128 | Oldest unread result |
| out_trig | output | 1 | Result available |
| pc_go | output | 1 | Precompute request pulse |
| pc_done | input | 1 | Precompute complete pulse |
| core_ready | input | 1 | Datapath can take a block |
| core_go | output | 1 | Block handed to the datapath |
| core_aad | output | 1 | Handed block is associated data |
| core_last | output | 1 | Handed block is the last of its phase |
| core_data | output | 128 | Handed block after padding |
| core_rvalid | input | 1 | Payload result valid |
| core_rdata | input | 128 | Payload result |
| tag_clr | output | 1 | Clear the tag accumulator |
| done | output | 1 | Stream complete pulse |
| tag_rdy | output | 1 | Tag may be read |
| err | output | 1 | Last start was rejected |

## Verification
The properties assume that the datapath honours its handshake. `core_rvalid` is only returned for payload blocks, one result for each block and in order. `pc_done` only pulses after a `pc_go`. The test bench models both sides with fixed-latency stubs that follow these rules. It writes only while `in_trig` is high and reads only while `out_trig` is high, so no stimulus goes outside the accepted protocol. Lengths are held steady across each start, except in the deliberate ignored-start case.

// File: rtl/gcm_seq_pkg.sv
// Package: shared phase encoding for the stream phase sequencer.
// Assumes: nothing beyond a 3-bit state vector.
package gcm_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PRECOMP = 3'd1,
        PH_AAD     = 3'd2,
        PH_PAYLOAD = 3'd3,
        PH_DRAIN   = 3'd4,
        PH_TAG     = 3'd5
    } phase_t;

endpackage

// File: rtl/gcm_len_calc.sv
// Converts a byte count into a block count (rounded up) and the number of
// valid bytes in the final block (1..BYTES).
// Assumes: BYTES is a power of two; a zero count yields zero blocks.
module gcm_len_calc #(
    parameter int LEN_W = 16,
    parameter int BYTES = 16,
    localparam int OFF_W = $clog2(BYTES),
    localparam int BLK_W = LEN_W - OFF_W + 1
) (
    input  logic [LEN_W-1:0] len,
    output logic [BLK_W-1:0] blocks,
    output logic [OFF_W:0]   tail
);

    logic [LEN_W:0] rounded;

    // round the byte count up to the next whole block
    always_comb begin
        rounded = {1'b0, len} + (LEN_W+1)'(BYTES - 1);
        blocks  = rounded[LEN_W:OFF_W];
    end

    // valid bytes in the last block; a whole block when aligned
    always_comb begin
        if (len[OFF_W-1:0] == '0)
            tail = (OFF_W+1)'(BYTES);
        else
            tail = {1'b0, len[OFF_W-1:0]};
    end

endmodule

// File: rtl/gcm_pad_mask.sv
// Zeroes every byte at or above the valid-byte count when the block is the
// last of its phase; otherwise the word passes unchanged.
// Assumes: byte i occupies bits [8i+7:8i]; tail in 1..BYTES.
module gcm_pad_mask #(
    parameter int DATA_W = 128,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] din,
    input  logic              last,
    input  logic [OFF_W:0]    tail,
    output logic [DATA_W-1:0] dout
);

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        logic keep;
        // one byte lane: kept unless it lies past the tail of a last block
        always_comb begin
            keep = !last || ((OFF_W+1)'(i) < tail);
            dout[8*i +: 8] = keep ? din[8*i +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/gcm_res_fifo.sv
// Small circular result buffer holding payload results until they are read.
// Assumes: the producer never pushes while full (the sequencer caps the
// number of outstanding blocks at DEPTH).
module gcm_res_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    // advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // head word and flags
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (cnt == '0);
        full  = (cnt == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/gcm_phase_seq.sv
// Top: phase sequencer for a GCM datapath. It latches block counts at
// start, gates the precompute, admits associated data and then payload,
// pads the last block of each phase, bounds outstanding payload results
// and reports done / tag ready.
// Assumes: datapath returns one in-order result per payload block only;
// pc_done pulses once per pc_go.
module gcm_phase_seq
    import gcm_seq_pkg::*;
#(
    parameter int DATA_W       = 128,
    parameter int AAD_W        = 16,
    parameter int LO_W         = 32,
    parameter int HI_W         = 4,
    parameter int MAX_INFLIGHT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AAD_W-1:0]  aad_len,
    input  logic [LO_W-1:0]   pay_len_lo,
    input  logic [HI_W-1:0]   pay_len_hi,
    input  logic              in_mask_en,
    input  logic              out_mask_en,
    input  logic              in_wr,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_trig,
    input  logic              out_rd,
    output logic [DATA_W-1:0] out_data,
    output logic              out_trig,
    output logic              pc_go,
    input  logic              pc_done,
    input  logic              core_ready,
    output logic              core_go,
    output logic              core_aad,
    output logic              core_last,
    output logic [DATA_W-1:0] core_data,
    input  logic              core_rvalid,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              tag_clr,
    output logic              done,
    output logic              tag_rdy,
    output logic              err
);

    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(BYTES);
    localparam int PL_W   = LO_W + HI_W;
    localparam int ABLK_W = AAD_W - OFF_W + 1;
    localparam int PBLK_W = PL_W - OFF_W + 1;
    localparam int PEND_W = $clog2(MAX_INFLIGHT + 1);

    phase_t state_q, state_d;

    logic [ABLK_W-1:0] aad_blk_in, aad_left_q;
    logic [PBLK_W-1:0] pay_blk_in, pay_left_q;
    logic [OFF_W:0]    aad_tail_in, pay_tail_in, aad_tail_q, pay_tail_q;
    logic [PEND_W-1:0] pend_q;
    logic              err_q, pc_go_q, tag_clr_q, done_q;

    logic start_window, len_zero, start_ok, start_bad;
    logic aad_open, pay_open, aad_accept, pay_accept;
    logic last_sel;
    logic [OFF_W:0] tail_sel;
    logic fifo_pop, fifo_empty, fifo_full;

    // length conversion for each stream
    gcm_len_calc #(.LEN_W(AAD_W), .BYTES(BYTES)) u_aad_len (
        .len    (aad_len),
        .blocks (aad_blk_in),
        .tail   (aad_tail_in)
    );

    gcm_len_calc #(.LEN_W(PL_W), .BYTES(BYTES)) u_pay_len (
        .len    ({pay_len_hi, pay_len_lo}),
        .blocks (pay_blk_in),
        .tail   (pay_tail_in)
    );

    // start qualification: only from idle or tag, and never with both zero
    always_comb begin
        start_window = (state_q == PH_IDLE) || (state_q == PH_TAG);
        len_zero     = (aad_len == '0) && (pay_len_lo == '0) && (pay_len_hi == '0);
        start_ok     = start && start_window && !len_zero;
        start_bad    = start && start_window && len_zero;
    end

    // intake gating: datapath free, and for payload a free result slot
    always_comb begin
        aad_open   = (state_q == PH_AAD) && core_ready;
        pay_open   = (state_q == PH_PAYLOAD) && core_ready &&
                     (pend_q < PEND_W'(MAX_INFLIGHT));
        aad_accept = aad_open && in_wr;
        pay_accept = pay_open && in_wr;
    end

    // phase transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE, PH_TAG: begin
                if (start_ok)       state_d = PH_PRECOMP;
                else if (start_bad) state_d = PH_IDLE;
            end
            PH_PRECOMP: begin
                if (pc_done)
                    state_d = (aad_left_q != '0) ? PH_AAD : PH_PAYLOAD;
            end
            PH_AAD: begin
                if (aad_accept && aad_left_q == ABLK_W'(1))
                    state_d = (pay_left_q != '0) ? PH_PAYLOAD : PH_DRAIN;
            end
            PH_PAYLOAD: begin
                if (pay_accept && pay_left_q == PBLK_W'(1))
                    state_d = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (pend_q == '0 && core_ready) state_d = PH_TAG;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // block counters and tails: loaded at start, counted down on intake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aad_left_q <= '0;
            pay_left_q <= '0;
            aad_tail_q <= '0;
            pay_tail_q <= '0;
        end else if (start_ok) begin
            aad_left_q <= aad_blk_in;
            pay_left_q <= pay_blk_in;
            aad_tail_q <= aad_tail_in;
            pay_tail_q <= pay_tail_in;
        end else begin
            if (aad_accept) aad_left_q <= aad_left_q - 1'b1;
            if (pay_accept) pay_left_q <= pay_left_q - 1'b1;
        end
    end

    // outstanding payload blocks: accepted but not yet read
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + PEND_W'(pay_accept) - PEND_W'(fifo_pop);
    end

    // pulses and the rejection flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            pc_go_q   <= 1'b0;
            tag_clr_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            pc_go_q   <= start_ok;
            tag_clr_q <= start_ok;
            done_q    <= (state_d == PH_TAG) && (state_q != PH_TAG);
            if (start_bad)     err_q <= 1'b1;
            else if (start_ok) err_q <= 1'b0;
        end
    end

    // last-block selection for the padding stage
    always_comb begin
        if (state_q == PH_AAD) begin
            last_sel = (aad_left_q == ABLK_W'(1));
            tail_sel = aad_tail_q;
        end else begin
            last_sel = (pay_left_q == PBLK_W'(1));
            tail_sel = pay_tail_q;
        end
    end

    gcm_pad_mask #(.DATA_W(DATA_W)) u_pad (
        .din  (in_data),
        .last (last_sel),
        .tail (tail_sel),
        .dout (core_data)
    );

    // result buffer between datapath and reader
    gcm_res_fifo #(.W(DATA_W), .DEPTH(MAX_INFLIGHT)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (core_rvalid),
        .din   (core_rdata),
        .pop   (fifo_pop),
        .dout  (out_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // port drive: datapath handoff, triggers, status
    always_comb begin
        fifo_pop  = out_rd && !fifo_empty;
        core_go   = aad_accept || pay_accept;
        core_aad  = (state_q == PH_AAD);
        core_last = last_sel;
        in_trig   = (aad_open || pay_open) && in_mask_en;
        out_trig  = !fifo_empty && out_mask_en;
        pc_go     = pc_go_q;
        tag_clr   = tag_clr_q;
        done      = done_q;
        tag_rdy   = (state_q == PH_TAG);
        err       = err_q;
    end

endmodule

// File: rtl/gcm_phase_seq_chk.sv
// Checker for gcm_phase_seq, attached by bind. Relates phase, handshakes and
// outputs over time.
// Assumes: the datapath returns results only for payload blocks.
module gcm_phase_seq_chk
    import gcm_seq_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int PEND_W = 2,
    parameter int MAX_INFLIGHT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        state,
    input logic              start_bad,
    input logic              err,
    input logic              pc_go,
    input logic              tag_clr,
    input logic              core_go,
    input logic              core_aad,
    input logic              core_last,
    input logic [DATA_W-1:0] core_data,
    input logic [4:0]        tail,
    input logic              core_rvalid,
    input logic              fifo_full,
    input logic              out_trig,
    input logic [PEND_W-1:0] pend,
    input logic              done,
    input logic              tag_rdy
);

    AST_NO_INTAKE_IN_PRECOMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PRECOMP) |-> !core_go);                                          // R2

    AST_ZERO_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> (err && !pc_go && !tag_clr));                                   // R3

    AST_AAD_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_AAD) |-> !out_trig);                                             // R4

    AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PEND_W'(MAX_INFLIGHT));                                               // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_rvalid |-> !fifo_full);                                                  // R6

    AST_LAST_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        (core_go && core_last && tail < 5'd16) |-> (core_data[DATA_W-1 -: 8] == 8'h00)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                              // R9

    AST_DONE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tag_rdy);                                                            // R9

endmodule

bind gcm_phase_seq gcm_phase_seq_chk #(
    .DATA_W(DATA_W), .PEND_W(PEND_W), .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .start_bad   (start_bad),
    .err         (err),
    .pc_go       (pc_go),
    .tag_clr     (tag_clr),
    .core_go     (core_go),
    .core_aad    (core_aad),
    .core_last   (core_last),
    .core_data   (core_data),
    .tail        (5'(tail_sel)),
    .core_rvalid (core_rvalid),
    .fifo_full   (fifo_full),
    .out_trig    (out_trig),
    .pend        (pend_q),
    .done        (done),
    .tag_rdy     (tag_rdy)
);

// File: tb/sim_gcm_phase_seq.sv
`timescale 1ns/1ps
module sim_gcm_phase_seq;

    localparam logic [127:0] KEYC = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  aad_len = '0;
    logic [31:0]  pay_len_lo = '0;
    logic [3:0]   pay_len_hi = '0;
    logic         in_mask_en = 1'b1;
    logic         out_mask_en = 1'b1;
    logic         in_wr = 1'b0;
    logic [127:0] in_data = '0;
    logic         in_trig;
    logic         out_rd = 1'b0;
    logic [127:0] out_data;
    logic         out_trig;
    logic         pc_go;
    logic         pc_done;
    logic         core_ready;
    logic         core_go, core_aad, core_last;
    logic [127:0] core_data;
    logic         core_rvalid;
    logic [127:0] core_rdata;
    logic         tag_clr, done, tag_rdy, err;

    int checks = 0;
    int errors = 0;
    int bench_pend = 0;
    int reads = 0;
    logic [127:0] expq[$];

    always #2 clk = ~clk;

    gcm_phase_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .aad_len(aad_len),
        .pay_len_lo(pay_len_lo), .pay_len_hi(pay_len_hi),
        .in_mask_en(in_mask_en), .out_mask_en(out_mask_en),
        .in_wr(in_wr), .in_data(in_data), .in_trig(in_trig),
        .out_rd(out_rd), .out_data(out_data), .out_trig(out_trig),
        .pc_go(pc_go), .pc_done(pc_done), .core_ready(core_ready),
        .core_go(core_go), .core_aad(core_aad), .core_last(core_last),
        .core_data(core_data), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
        .tag_clr(tag_clr), .done(done), .tag_rdy(tag_rdy), .err(err)
    );

    // precompute stub: fixed latency of five cycles
    logic [2:0] pc_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)           pc_cnt <= '0;
        else if (pc_go)       pc_cnt <= 3'd5;
        else if (pc_cnt != 0) pc_cnt <= pc_cnt - 1'b1;
    end
    assign pc_done = (pc_cnt == 3'd1);

    // datapath stub: three-cycle latency, result = block xor KEYC for payload
    logic         st_busy, st_aad, seen_pay;
    logic [1:0]   st_lat;
    logic [127:0] st_data, last_aad_blk;
    int aad_cnt, pay_cnt, last_cnt, order_bad;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_busy <= 0; st_lat <= 0; core_rvalid <= 0; seen_pay <= 0;
            aad_cnt <= 0; pay_cnt <= 0; last_cnt <= 0; order_bad <= 0;
        end else begin
            core_rvalid <= 0;
            if (start) seen_pay <= 0;
            if (core_go) begin
                st_busy <= 1; st_lat <= 2'd3; st_data <= core_data; st_aad <= core_aad;
                if (core_aad) begin
                    aad_cnt <= aad_cnt + 1;
                    if (seen_pay) order_bad <= order_bad + 1;
                    if (core_last) last_aad_blk <= core_data;
                end else begin
                    pay_cnt <= pay_cnt + 1;
                    seen_pay <= 1;
                end
                if (core_last) last_cnt <= last_cnt + 1;
            end else if (st_busy) begin
                if (st_lat == 2'd1) begin
                    st_busy <= 0;
                    if (!st_aad) begin
                        core_rvalid <= 1;
                        core_rdata  <= st_data ^ KEYC;
                    end
                end
                st_lat <= st_lat - 1'b1;
            end
        end
    end
    assign core_ready = !st_busy;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input int s, input int b);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'(8'h81 + i*7 + b*13 + s*29) | 8'h01;
        return r;
    endfunction

    function automatic logic [127:0] padf(input logic [127:0] d, input int vb);
        logic [127:0] r = d;
        for (int i = 0; i < 16; i++) if (i >= vb) r[8*i +: 8] = 8'h00;
        return r;
    endfunction

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_sim();
    end

    // monitor: read a result whenever offered, compare against scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (out_trig) begin
                if (expq.size() == 0)
                    chk(0, "R4", "unexpected result", out_data, '0);
                else
                    chk(out_data == expq[0], "R5", "result order/value", out_data, expq[0]);
                if (expq.size() != 0) void'(expq.pop_front());
                out_rd = 1;
                reads++;
                bench_pend--;
            end else begin
                out_rd = 0;
            end
        end
    end

    task automatic wait_trig();
        forever begin
            @(negedge clk);
            if (in_trig) begin
                if (bench_pend >= 2) chk(0, "R6", "trigger with two pending", bench_pend, 1);
                break;
            end
        end
    endtask

    task automatic push_word(input logic [127:0] d, input bit is_pay);
        in_wr = 1; in_data = d;
        @(posedge clk); #0.5;
        in_wr = 0;
        if (is_pay) bench_pend++;
    endtask

    // driver: one complete stream, pushing expected results to the scoreboard
    task automatic run_stream(input int s, input int aad, input int pay,
                              input bit in_mtest, input bit hold, input bit poke);
        int ab = (aad + 15) / 16;
        int pb = (pay + 15) / 16;
        int at = (aad % 16 == 0) ? 16 : aad % 16;
        int pt = (pay % 16 == 0) ? 16 : pay % 16;
        int a0 = aad_cnt, p0 = pay_cnt, l0 = last_cnt, r0 = reads;
        int cyc;
        logic [127:0] exp_last_aad = '0;
        aad_len = 16'(aad); pay_len_lo = 32'(pay); pay_len_hi = 0;
        @(negedge clk); start = 1;
        @(posedge clk); #0.5; start = 0;
        @(negedge clk);
        chk(pc_go && tag_clr, "R2", "pc_go/tag_clr pulse", {pc_go, tag_clr}, 2'b11);
        chk(!err, "R3", "err clear on legal start", err, 0);
        chk(!in_trig, "R2", "no request during precompute", in_trig, 0);
        if (in_mtest) begin
            in_mask_en = 0;
            cyc = 0;
            repeat (12) begin @(negedge clk); if (in_trig) cyc++; end
            chk(cyc == 0, "R8", "masked input trigger", cyc, 0);
            in_mask_en = 1;
        end
        for (int b = 0; b < ab; b++) begin
            wait_trig();
            if (b == ab - 1) exp_last_aad = padf(pat(s, b), at);
            push_word(pat(s, b), 0);
        end
        if (hold) out_mask_en = 0;
        for (int b = 0; b < pb; b++) begin
            if (hold && b == 2) begin
                repeat (12) @(negedge clk);
                chk(!in_trig, "R6", "input held at two pending", in_trig, 0);
                chk(!out_trig, "R8", "masked output trigger", out_trig, 0);
                out_mask_en = 1;
                @(negedge clk);
                chk(out_trig, "R8", "result kept while masked", out_trig, 1);
            end
            wait_trig();
            expq.push_back(((b == pb - 1) ? padf(pat(s, 100 + b), pt) : pat(s, 100 + b)) ^ KEYC);
            if (poke && b == 1) begin
                start = 1; pay_len_lo = 32'd16; aad_len = 16'd48;
            end
            push_word(pat(s, 100 + b), 1);
            start = 0; aad_len = 16'(aad); pay_len_lo = 32'(pay);
        end
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        chk(done && tag_rdy, "R9", "done with tag ready", {done, tag_rdy}, 2'b11);
        @(negedge clk);
        chk(!done && tag_rdy, "R9", "done one cycle, tag held", {done, tag_rdy}, 2'b01);
        chk(aad_cnt - a0 == ab, "R4", "aad block count", aad_cnt - a0, ab);
        chk(order_bad == 0, "R4", "aad after payload", order_bad, 0);
        chk(pay_cnt - p0 == pb, poke ? "R10" : "R5", "payload block count", pay_cnt - p0, pb);
        chk(reads - r0 == pb, "R4", "results only for payload", reads - r0, pb);
        chk(expq.size() == 0, "R5", "scoreboard drained", expq.size(), 0);
        chk(last_cnt - l0 == (ab > 0) + (pb > 0), "R7", "last flags", last_cnt - l0, (ab > 0) + (pb > 0));
        if (ab > 0) chk(last_aad_blk == exp_last_aad, "R7", "aad tail padding", last_aad_blk, exp_last_aad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1;
        @(negedge clk);
        chk({in_trig, out_trig, pc_go, tag_clr, done, tag_rdy, err} == 0, "R1",
            "reset state", {in_trig, out_trig, pc_go, tag_clr, done, tag_rdy, err}, 0);

        // both lengths zero: rejected
        @(negedge clk); start = 1;
        @(posedge clk); #0.5; start = 0;
        @(negedge clk);
        chk(err && !pc_go && !tag_clr, "R3", "zero-length reject", {err, pc_go, tag_clr}, 3'b100);
        repeat (8) @(negedge clk);
        chk(!in_trig && !tag_rdy && !pc_go, "R3", "stays idle", {in_trig, tag_rdy, pc_go}, 0);

        run_stream(1, 20, 40, 1, 0, 0);   // partial tails, input mask test
        run_stream(2, 0, 64, 0, 1, 1);    // aligned payload, hold, ignored start (R10)
        run_stream(3, 33, 0, 0, 0, 0);    // associated data only (R11 restart from tag)
        run_stream(4, 16, 17, 0, 0, 0);   // R11 new lengths again

        // high part of the payload count: 2^32 bytes, legal, many blocks
        aad_len = 0; pay_len_lo = 0; pay_len_hi = 4'd1;
        @(negedge clk); start = 1;
        @(posedge clk); #0.5; start = 0;
        @(negedge clk);
        chk(pc_go && !err, "R5", "high part counts as non-zero", {pc_go, err}, 2'b10);
        wait_trig();
        chk(core_aad == 0 && core_last == 0, "R5", "payload phase, not last block",
            {core_aad, core_last}, 0);
        finish_sim();
    end

endmodule